// File: doc/BRIEF.md
# Fast Interrupt Entry Selector

This block sits between the interrupt arbiter and the CPU front end. When the arbiter accepts a request, the block looks at its priority level and group. It checks two programmable fast-entry slots. If a slot matches, the block gives the CPU the segment and offset of the service routine directly, so the CPU skips the two chained branches through the vector table. That path is 4 CPU cycles shorter.

For the four top priority levels (12 to 15), the block also looks up a 2-bit register-bank code. A table of four 16-bit words holds these codes, one word per level and one 2-bit field per group. The block presents the code with a load strobe, so the CPU can write it straight into the bank field of its status word. The new bank can then be used in the next cycle.

Software programs the slots and the bank table through a simple write port. All results are registered and appear one cycle after the acceptance.

Top module: `fast_entry_sel`

## Requirements
- R1: After synchronous reset, all configuration words are 0x0000: no slot is enabled and every bank code selects the global bank. All outputs are low or zero.
- R2: `ent_valid` pulses for exactly one cycle, in the cycle after each cycle in which `acc_valid` is high. In any cycle that does not follow an acceptance, `ent_valid`, `ent_hit` and `bank_load` are low.
- R3: A slot control word carries four fields. Bit 15 is the enable. Bits 14:12 hold the group. Bits 11:10 hold the level minus 12. Bits 7:0 hold the code segment. A slot matches an accepted request when the slot is enabled, the request level is 12 to 15, and both level and group are equal. On a match, `ent_hit` is high and `ent_seg`/`ent_off` carry that slot's segment and 16-bit offset.
- R4: When both slots match the same request, slot 0 supplies the routine address.
- R5: A slot with bit 15 clear never produces a hit, whatever its other fields hold.
- R6: A request at a level below 12 never hits and never raises `bank_load`, even if its low two level bits and its group match a slot.
- R7: An accepted request at level 12 to 15 raises `bank_load`. `bank_sel` then carries bits [2g+1:2g] of the bank word for that level, where g is the group. Codes: 00 global, 10 local bank 1, 11 local bank 2.
- R8: The reserved bank code 01 is delivered as 00 (global bank).
- R9: Write addresses are as follows. 0 and 2 are the control words of slots 0 and 1. 1 and 3 are the offsets of slots 0 and 1. 4 to 7 are the bank words for levels 12 to 15. A write takes effect after its clock edge, so an acceptance in the same cycle still sees the old value.
- R10: Whenever `ent_hit` is low, `ent_seg` and `ent_off` are zero, and `bank_sel` is zero whenever `bank_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| acc_valid | input | 1 | Arbiter accepted a request this cycle |
| acc_level | input | 4 | Priority level of the accepted request |
| acc_group | input | 3 | Group of the accepted request |
| ent_valid | output | 1 | Entry result valid (one cycle after acceptance) |
| ent_hit | output | 1 | A fast-entry slot matched |
| ent_seg | output | 8 | Routine code segment on a hit |
| ent_off | output | 16 | Routine offset on a hit |
| bank_load | output | 1 | Strobe to load the status-word bank field |
| bank_sel | output | 2 | Bank code to load |

## Verification
The assertions check every cycle that the response follows an acceptance by one cycle and is quiet otherwise. They also check that low levels never hit or load a bank, that top levels always load one, that a reserved code never reaches `bank_sel`, and that address and bank outputs are zero when not asserted. Only the bench's scenarios can show other behaviour: that the right slot wins when both match, that field positions and bank table indexing are correct, and that a write in the same cycle as an acceptance is not seen. The bench does this by comparing every cycle against a behavioural model under both directed and pseudo-random traffic.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int LVL_W    = 4;
    localparam int GRP_W    = 3;
    localparam int RLVL_W   = 2;   // level relative to the lowest fast level
    localparam int SEG_W    = 8;
    localparam int OFF_W    = 16;
    localparam int BANK_W   = 2;
    localparam int WORD_W   = 16;
    localparam int N_FAST_LVL = 1 << RLVL_W;
    localparam int N_GROUP    = 1 << GRP_W;

    typedef enum logic [BANK_W-1:0] {
        BANK_GLOBAL = 2'b00,
        BANK_RSVD   = 2'b01,
        BANK_LOCAL1 = 2'b10,
        BANK_LOCAL2 = 2'b11
    } bank_e;

    typedef struct packed {
        logic              en;
        logic [GRP_W-1:0]  grp;
        logic [RLVL_W-1:0] rlvl;
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
    } slot_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } entry_t;

    // Fast levels are 12..15: the two upper level bits are both set.
    function automatic logic is_fast_level(input logic [LVL_W-1:0] lvl);
        return lvl[LVL_W-1 -: 2] == 2'b11;
    endfunction

    // The reserved code selects the global bank.
    function automatic bank_e sanitize_bank(input logic [BANK_W-1:0] code);
        return (code == BANK_RSVD) ? BANK_GLOBAL : bank_e'(code);
    endfunction

endpackage

// File: rtl/fes_regs.sv
module fes_regs
    import fes_pkg::*;
#(
    parameter int N_SLOT = 2,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    output slot_cfg_t [N_SLOT-1:0]          slots,
    output logic [N_FAST_LVL-1:0][WORD_W-1:0] bsel
);
    localparam int BSEL_BASE = 2 * N_SLOT;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[s] <= '0;
            end else if (we && int'(addr) == 2*s) begin
                slots[s].en   <= wdata[15];
                slots[s].grp  <= wdata[14:12];
                slots[s].rlvl <= wdata[11:10];
                slots[s].seg  <= wdata[SEG_W-1:0];
            end else if (we && int'(addr) == 2*s + 1) begin
                slots[s].off  <= wdata;
            end
        end
    end

    for (genvar l = 0; l < N_FAST_LVL; l++) begin : g_bsel
        always_ff @(posedge clk) begin
            if (rst)
                bsel[l] <= '0;
            else if (we && int'(addr) == BSEL_BASE + l)
                bsel[l] <= wdata;
        end
    end

endmodule

// File: rtl/fes_match.sv
module fes_match
    import fes_pkg::*;
#(
    parameter int N_SLOT = 2
) (
    input  slot_cfg_t [N_SLOT-1:0] slots,
    input  logic [LVL_W-1:0]       level,
    input  logic [GRP_W-1:0]       group,
    output entry_t                 entry
);
    logic [N_SLOT-1:0] slot_hit;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_cmp
        assign slot_hit[s] = slots[s].en && is_fast_level(level) &&
                             slots[s].rlvl == level[RLVL_W-1:0] &&
                             slots[s].grp  == group;
    end

    // Lowest slot index has priority: scan downward so it is assigned last.
    always_comb begin
        entry = '0;
        for (int s = N_SLOT - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                entry.hit = 1'b1;
                entry.seg = slots[s].seg;
                entry.off = slots[s].off;
            end
        end
    end

endmodule

// File: rtl/fes_bank.sv
module fes_bank
    import fes_pkg::*;
(
    input  logic [N_FAST_LVL-1:0][WORD_W-1:0] bsel,
    input  logic [LVL_W-1:0]                  level,
    input  logic [GRP_W-1:0]                  group,
    output logic                              load,
    output bank_e                             bank
);
    logic [WORD_W-1:0] word;
    logic [BANK_W-1:0] code;

    assign word = bsel[level[RLVL_W-1:0]];
    assign code = word[{group, 1'b0} +: BANK_W];
    assign load = is_fast_level(level);
    assign bank = load ? sanitize_bank(code) : BANK_GLOBAL;

endmodule

// File: rtl/fast_entry_sel.sv
module fast_entry_sel
    import fes_pkg::*;
#(
    parameter int N_SLOT = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [3:0]        acc_level,
    input  logic [2:0]        acc_group,
    output logic              ent_valid,
    output logic              ent_hit,
    output logic [7:0]        ent_seg,
    output logic [15:0]       ent_off,
    output logic              bank_load,
    output logic [1:0]        bank_sel
);
    slot_cfg_t [N_SLOT-1:0]            slots;
    logic [N_FAST_LVL-1:0][WORD_W-1:0] bsel;
    entry_t                            entry_c;
    logic                              load_c;
    bank_e                             bank_c;

    fes_regs #(.N_SLOT(N_SLOT), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .slots (slots),
        .bsel  (bsel)
    );

    fes_match #(.N_SLOT(N_SLOT)) u_match (
        .slots (slots),
        .level (acc_level),
        .group (acc_group),
        .entry (entry_c)
    );

    fes_bank u_bank (
        .bsel  (bsel),
        .level (acc_level),
        .group (acc_group),
        .load  (load_c),
        .bank  (bank_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !acc_valid) begin
            ent_valid <= 1'b0;
            ent_hit   <= 1'b0;
            ent_seg   <= '0;
            ent_off   <= '0;
            bank_load <= 1'b0;
            bank_sel  <= '0;
        end else begin
            ent_valid <= 1'b1;
            ent_hit   <= entry_c.hit;
            ent_seg   <= entry_c.seg;
            ent_off   <= entry_c.off;
            bank_load <= load_c;
            bank_sel  <= bank_c;
        end
    end

endmodule

// File: rtl/fast_entry_sel_chk.sv
module fast_entry_sel_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic [3:0]  acc_level,
    input logic        ent_valid,
    input logic        ent_hit,
    input logic [7:0]  ent_seg,
    input logic [15:0] ent_off,
    input logic        bank_load,
    input logic [1:0]  bank_sel
);
    p_resp_follows_acc_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> ent_valid);

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!ent_valid && !ent_hit && !bank_load));

    p_low_level_no_fast_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_level < 4'd12) |=> (!ent_hit && !bank_load));

    p_top_level_loads_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_level >= 4'd12) |=> bank_load);

    p_no_reserved_code_r8: assert property (@(posedge clk) disable iff (rst)
        bank_load |-> bank_sel != 2'b01);

    p_hit_inside_valid_r3: assert property (@(posedge clk) disable iff (rst)
        ent_hit |-> ent_valid);

    p_miss_zero_addr_r10: assert property (@(posedge clk) disable iff (rst)
        !ent_hit |-> (ent_seg == 8'h00 && ent_off == 16'h0000));

    p_no_load_zero_bank_r10: assert property (@(posedge clk) disable iff (rst)
        !bank_load |-> bank_sel == 2'b00);

endmodule

bind fast_entry_sel fast_entry_sel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_level (acc_level),
    .ent_valid (ent_valid),
    .ent_hit   (ent_hit),
    .ent_seg   (ent_seg),
    .ent_off   (ent_off),
    .bank_load (bank_load),
    .bank_sel  (bank_sel)
);

// File: tb/fast_entry_sel_test.sv
`timescale 1ns/1ps
module fast_entry_sel_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        acc_valid;
    logic [3:0]  acc_level;
    logic [2:0]  acc_group;
    logic        ent_valid, ent_hit, bank_load;
    logic [7:0]  ent_seg;
    logic [15:0] ent_off;
    logic [1:0]  bank_sel;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    logic [15:0] m_ctrl [2];
    logic [15:0] m_off  [2];
    logic [15:0] m_bsel [4];
    logic [28:0] exp_v;

    always #4 clk = ~clk;   // 125 MHz

    fast_entry_sel uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_level(acc_level), .acc_group(acc_group),
        .ent_valid(ent_valid), .ent_hit(ent_hit), .ent_seg(ent_seg),
        .ent_off(ent_off), .bank_load(bank_load), .bank_sel(bank_sel)
    );

    function automatic logic [28:0] model_resp(input bit rv, input int lv, input int gp);
        bit hit = 0;
        logic [7:0]  seg = 8'h00;
        logic [15:0] off = 16'h0000;
        bit ld = 0;
        int bk = 0;
        int li;
        if (!rv) return '0;
        li = lv - 12;
        for (int s = 0; s < 2; s++) begin
            if (!hit && lv >= 12 && m_ctrl[s][15] &&
                int'(m_ctrl[s][11:10]) == li && int'(m_ctrl[s][14:12]) == gp) begin
                hit = 1;
                seg = m_ctrl[s][7:0];
                off = m_off[s];
            end
        end
        if (lv >= 12) begin
            ld = 1;
            bk = int'((m_bsel[li] >> (2 * gp)) & 16'h3);
            if (bk == 1) bk = 0;
        end
        return {1'b1, hit, seg, off, ld, 2'(bk)};
    endfunction

    task automatic check_out(input string tag);
        logic [28:0] act;
        act = {ent_valid, ent_hit, ent_seg, ent_off, bank_load, bank_sel};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h (valid,hit,seg,off,load,bank)", tag, act, exp_v);
        end
    endtask

    // one clock: drive, model at the edge, compare at the falling edge
    task automatic cyc(input bit we, input logic [2:0] wa, input logic [15:0] wd,
                       input bit rv, input int lv, input int gp, input string tag);
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        acc_valid = rv; acc_level = 4'(lv); acc_group = 3'(gp);
        @(posedge clk);
        exp_v = model_resp(rv, lv, gp);
        if (we) begin
            case (int'(wa))
                0: m_ctrl[0] = wd;
                1: m_off[0]  = wd;
                2: m_ctrl[1] = wd;
                3: m_off[1]  = wd;
                default: m_bsel[int'(wa) - 4] = wd;
            endcase
        end
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        cyc(1, a, d, 0, 0, 0, tag);
    endtask

    task automatic acc(input int lv, input int gp, input string tag);
        cyc(0, 3'd0, 16'h0, 1, lv, gp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        acc_valid = 0; acc_level = 0; acc_group = 0;
        for (int i = 0; i < 2; i++) begin m_ctrl[i] = 0; m_off[i] = 0; end
        for (int i = 0; i < 4; i++) m_bsel[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_v = '0;
        check_out("R1 reset outputs");
        rst = 1'b0;

        // R1: empty configuration, top level -> miss with global bank load
        acc(15, 0, "R1 miss after reset");
        acc(12, 5, "R1 global bank after reset");
        cyc(0, 0, 0, 0, 0, 0, "R2 idle cycle");

        // R3 / R9: program slot 0 (enabled, level 15, group 0)
        wr(3'd0, 16'h8C00, "R9 write slot0 ctrl");
        wr(3'd1, 16'h1234, "R9 write slot0 offset");
        acc(15, 0, "R3 slot0 hit");
        // slot 1: enabled, group 1, level 15, segment 0x45
        wr(3'd2, 16'h9D45, "R9 write slot1 ctrl");
        wr(3'd3, 16'hBEEF, "R9 write slot1 offset");
        acc(15, 1, "R3 slot1 hit");
        acc(14, 1, "R3 level mismatch miss");
        acc(15, 2, "R10 group mismatch miss zeros");
        // R2: back-to-back acceptances
        acc(15, 0, "R2 back to back a");
        acc(15, 1, "R2 back to back b");

        // R4: both slots match level 15 group 0
        wr(3'd2, 16'h8C77, "R9 rewrite slot1 ctrl");
        wr(3'd3, 16'h5555, "R9 rewrite slot1 offset");
        acc(15, 0, "R4 slot0 priority");
        // R5: disable slot 0, keep its other fields
        wr(3'd0, 16'h0C00, "R5 disable slot0");
        acc(15, 0, "R5 disabled slot skipped");
        wr(3'd2, 16'h0C77, "R5 disable slot1");
        acc(15, 0, "R5 both disabled miss");

        // R6: level 11 has the same low bits as level 15
        wr(3'd0, 16'h8C00, "R6 reenable slot0");
        acc(11, 0, "R6 level 11 no hit");
        acc(3, 0, "R6 level 3 no hit");

        // R7: bank table lookups
        wr(3'd4, 16'h0002, "R7 level12 group0 local1");
        acc(12, 0, "R7 bank local1");
        wr(3'd5, 16'h0300, "R7 level13 group4 local2");
        acc(13, 4, "R7 bank local2");
        acc(13, 3, "R7 neighbour field global");
        // R8: reserved code in level 14 group 7
        wr(3'd6, 16'h4000, "R8 write reserved code");
        acc(14, 7, "R8 reserved as global");

        // R9: write and acceptance in the same cycle
        cyc(1, 3'd7, 16'h0003, 1, 15, 0, "R9 same cycle sees old bank");
        acc(15, 0, "R9 new bank visible");
        cyc(1, 3'd1, 16'hAAAA, 1, 15, 0, "R9 same cycle sees old offset");
        acc(15, 0, "R9 new offset visible");

        // pseudo-random traffic against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            bit we, rv;
            logic [2:0]  wa;
            logic [15:0] wd;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            we = (lfsr[2:0] == 3'd0);
            wa = lfsr[5:3];
            wd = {lfsr[15], lfsr[6:4], 2'b11 & lfsr[9:8], 2'b00, lfsr[14:7]};
            rv = lfsr[11] | lfsr[1];
            cyc(we, wa, wd, rv, int'(lfsr[15:12]), int'(lfsr[10:8]), "R3 random traffic");
        end

        cyc(0, 0, 0, 0, 0, 0, "R2 final idle");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule